// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block turns a simple internal request port into accesses on an external 8-bit multiplexed parallel memory bus. The requester gives an address, a read/write flag and write data, and holds `req_valid` high. The block then runs one bus access and raises `req_ready` for a single cycle when the access is done. For reads, the returned byte is on `rsp_rdata` in that same cycle. On the external side, one byte-wide bus carries the low address byte while the latch-enable strobe is high and carries data during the read or write strobe. The high address byte has dedicated pins and keeps its value for the whole access.

Two small registers configure the block. The control register holds the enable bit and a legacy timing mode. The sector register holds a lower-sector wait field, an upper-sector wait field and a three-bit boundary field. When the block is enabled it owns every bus pin. This holds whatever direction and output values the general-purpose port logic presents. When it is disabled, the port logic's values pass straight to the pins. An input from the core tells the block whether the access after the current one also targets RAM. The block uses it to decide whether the latch-enable strobe pulses in the last cycle of an access.

Top module: `emb_bus_ctrl`

## Requirements
- R1: After reset, both configuration registers read 0x00, `req_ready` is low, and the block is disabled, so every pin follows the port logic.
- R2: With control bit 0 (enable) at 0, every pin output and enable equals the matching `gpio_*` input, and no access starts. With enable at 1, `pin_ahi_oe` is all ones and `pin_ctl_oe` is 3'b111, whatever the port logic drives.
- R3: The first cycle of an access has latch enable high, `pin_ad_out` equal to the low address byte with `pin_ad_oe` all ones, and both strobes high. `pin_ahi_out` equals the high address byte in every cycle of the access.
- R4: In a write, `pin_ad_out` carries the write data with `pin_ad_oe` all ones in every cycle where the write strobe is low, from the cycle after latch enable falls. The read strobe stays high.
- R5: In a read, `pin_ad_oe` is zero while the read strobe is low. The byte on `pin_ad_in` at the clock edge where the read strobe rises appears on `rsp_rdata` in the `req_ready` cycle.
- R6: A 2-bit wait field selects the strobe length and hold time. 00 gives a one-cycle strobe. 01 gives a two-cycle strobe. 10 gives a three-cycle strobe. 11 gives a three-cycle strobe followed by one idle cycle with both strobes high before the final cycle.
- R7: The sector register holds the boundary field in bits [6:4], the upper wait field in [3:2] and the lower wait field in [1:0]. With boundary value L not 0, an address below 0x1100 + L*0x2000 uses the lower field and the rest use the upper field. With L = 0, every address uses the upper field.
- R8: With control bit 1 (legacy) at 1, bit 2 of the sector register alone sets the timing: 1 gives a two-cycle strobe and 0 a one-cycle strobe, never with a hold cycle. The lower field and the boundary are then ignored.
- R9: In the final cycle of an access (the `req_ready` cycle), latch enable equals `next_ram_hint`. Both strobes are high and `pin_ad_oe` is zero.
- R10: Sector register bit 7 always reads 0, and writes to it are ignored. Control register bits [7:2] always read 0.
- R11: `req_ready` is low in every cycle except the final cycle of an access, and it is high for exactly one cycle per access.
- R12: The pin vector `pin_ctl_out` is {latch enable, write strobe, read strobe} in bits [2], [1], [0], and both strobes are active low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_addr | input | 1 | Register select: 0 control, 1 sector |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Read value of the selected register |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | High in the final cycle of an access |
| req_addr | input | 16 | Access address |
| req_we | input | 1 | 1 write, 0 read |
| req_wdata | input | 8 | Write data |
| rsp_rdata | output | 8 | Read data, valid with req_ready |
| next_ram_hint | input | 1 | The following access targets RAM |
| gpio_ad_out | input | 8 | Port logic value for the multiplexed bus pins |
| gpio_ad_oe | input | 8 | Port logic enables for the multiplexed bus pins |
| gpio_ahi_out | input | 8 | Port logic value for the high address pins |
| gpio_ahi_oe | input | 8 | Port logic enables for the high address pins |
| gpio_ctl_out | input | 3 | Port logic value for the three control pins |
| gpio_ctl_oe | input | 3 | Port logic enables for the three control pins |
| pin_ad_in | input | 8 | Value read from the multiplexed bus pins |
| pin_ad_out | output | 8 | Multiplexed bus pin output |
| pin_ad_oe | output | 8 | Multiplexed bus pin enables |
| pin_ahi_out | output | 8 | High address pin output |
| pin_ahi_oe | output | 8 | High address pin enables |
| pin_ctl_out | output | 3 | Control pins {latch enable, write strobe, read strobe} |
| pin_ctl_oe | output | 3 | Control pin enables |

## Verification
The assertions assume three things about the inputs. The enable bit and the sector register do not change while an access is in progress. The requester drops `req_valid` in the cycle where it sees `req_ready`, or keeps a steady request. `next_ram_hint` is settled in the final cycle. The stimulus writes configuration only while the block is idle, and it presents one request at a time. It drives `req_valid` low on the falling edge that follows the `req_ready` cycle. To show that read data is taken at the edge where the read strobe rises and not later, the bench inverts the byte on `pin_ad_in` in the cycle after that edge.

// File: rtl/emb_pkg.sv
package emb_pkg;

    localparam int REG_W = 8;
    localparam int LIM_W = 3;
    localparam int WS_W  = 2;

    localparam logic SEL_CTRL = 1'b0;
    localparam logic SEL_SECT = 1'b1;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_STRB,
        PH_HOLD,
        PH_END
    } phase_e;

    typedef struct packed {
        logic             enable;
        logic             legacy;
        logic [LIM_W-1:0] limit;
        logic [WS_W-1:0]  up_ws;
        logic [WS_W-1:0]  lo_ws;
    } cfg_t;

    typedef struct packed {
        logic [1:0] extra;
        logic       hold;
    } timing_t;

    typedef struct packed {
        logic ale;
        logic wr_n;
        logic rd_n;
    } ctl_t;

    function automatic timing_t decode_ws(input logic [WS_W-1:0] f);
        timing_t t;
        case (f)
            2'b00:   t.extra = 2'd0;
            2'b01:   t.extra = 2'd1;
            default: t.extra = 2'd2;
        endcase
        t.hold = (f == 2'b11);
        return t;
    endfunction

    function automatic timing_t legacy_ws(input logic wait_bit);
        timing_t t;
        t.extra = {1'b0, wait_bit};
        t.hold  = 1'b0;
        return t;
    endfunction

endpackage

// File: rtl/emb_cfg_regs.sv
module emb_cfg_regs
    import emb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic             cfg_addr,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    output cfg_t             cfg
);

    cfg_t cfg_q;
    logic unused_wbits;

    assign unused_wbits = cfg_wdata[REG_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (cfg_we) begin
            if (cfg_addr == SEL_CTRL) begin
                cfg_q.enable <= cfg_wdata[0];
                cfg_q.legacy <= cfg_wdata[1];
            end else begin
                cfg_q.limit <= cfg_wdata[6:4];
                cfg_q.up_ws <= cfg_wdata[3:2];
                cfg_q.lo_ws <= cfg_wdata[1:0];
            end
        end
    end

    always_comb begin
        if (cfg_addr == SEL_CTRL)
            cfg_rdata = {{(REG_W-2){1'b0}}, cfg_q.legacy, cfg_q.enable};
        else
            cfg_rdata = {1'b0, cfg_q.limit, cfg_q.up_ws, cfg_q.lo_ws};
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/emb_sector_sel.sv
module emb_sector_sel
    import emb_pkg::*;
#(
    parameter int          ADDR_W      = 16,
    parameter int unsigned RAM_TOP     = 32'h0000_10FF,
    parameter int unsigned SECTOR_STEP = 32'h0000_2000
) (
    input  logic [ADDR_W-1:0] addr,
    input  cfg_t              cfg,
    output timing_t           tim
);

    localparam int          N_LIM = 1 << LIM_W;
    localparam int unsigned BASE  = RAM_TOP + 1;

    logic [N_LIM-1:0] below;
    logic             in_lower;

    assign below[0] = 1'b0;

    generate
        for (genvar g = 1; g < N_LIM; g++) begin : g_edge
            localparam logic [31:0] EDGE_V = 32'(BASE + 32'(g) * SECTOR_STEP);
            assign below[g] = (32'(addr) < EDGE_V);
        end
    endgenerate

    assign in_lower = below[cfg.limit];

    always_comb begin
        if (cfg.legacy)
            tim = legacy_ws(cfg.up_ws[0]);
        else if (in_lower)
            tim = decode_ws(cfg.lo_ws);
        else
            tim = decode_ws(cfg.up_ws);
    end

endmodule

// File: rtl/emb_seq.sv
module emb_seq
    import emb_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en,
    input  logic                     req_valid,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic                     req_we,
    input  logic [DATA_W-1:0]        req_wdata,
    input  timing_t                  req_tim,
    input  logic                     next_ram_hint,
    input  logic [DATA_W-1:0]        ad_in,
    output logic                     req_ready,
    output logic [DATA_W-1:0]        rsp_rdata,
    output ctl_t                     bus_ctl,
    output logic [DATA_W-1:0]        bus_ad,
    output logic                     bus_ad_oe,
    output logic [ADDR_W-DATA_W-1:0] bus_ahi
);

    phase_e              ph;
    logic [ADDR_W-1:0]   a_q;
    logic                we_q;
    logic [DATA_W-1:0]   wd_q;
    logic [DATA_W-1:0]   rd_q;
    timing_t             tim_q;
    logic [1:0]          cnt;
    logic                strobe;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph    <= PH_IDLE;
            a_q   <= '0;
            we_q  <= 1'b0;
            wd_q  <= '0;
            rd_q  <= '0;
            tim_q <= '0;
            cnt   <= '0;
        end else begin
            case (ph)
                PH_IDLE: begin
                    if (en && req_valid) begin
                        a_q   <= req_addr;
                        we_q  <= req_we;
                        wd_q  <= req_wdata;
                        tim_q <= req_tim;
                        ph    <= PH_ADDR;
                    end
                end
                PH_ADDR: begin
                    cnt <= tim_q.extra;
                    ph  <= PH_STRB;
                end
                PH_STRB: begin
                    if (cnt == 2'd0) begin
                        if (!we_q)
                            rd_q <= ad_in;
                        ph <= tim_q.hold ? PH_HOLD : PH_END;
                    end else begin
                        cnt <= cnt - 2'd1;
                    end
                end
                PH_HOLD: ph <= PH_END;
                PH_END:  ph <= PH_IDLE;
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign strobe       = (ph == PH_STRB);
    assign bus_ctl.ale  = (ph == PH_ADDR) || ((ph == PH_END) && next_ram_hint);
    assign bus_ctl.wr_n = !(strobe && we_q);
    assign bus_ctl.rd_n = !(strobe && !we_q);
    assign bus_ad       = (ph == PH_ADDR) ? a_q[DATA_W-1:0] : wd_q;
    assign bus_ad_oe    = (ph == PH_ADDR) || (strobe && we_q);
    assign bus_ahi      = a_q[ADDR_W-1:DATA_W];
    assign req_ready    = (ph == PH_END);
    assign rsp_rdata    = rd_q;

endmodule

// File: rtl/emb_pin_mux.sv
module emb_pin_mux
    import emb_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int HI_W   = 8
) (
    input  logic              en,
    input  ctl_t              bus_ctl,
    input  logic [DATA_W-1:0] bus_ad,
    input  logic              bus_ad_oe,
    input  logic [HI_W-1:0]   bus_ahi,
    input  logic [DATA_W-1:0] gpio_ad_out,
    input  logic [DATA_W-1:0] gpio_ad_oe,
    input  logic [HI_W-1:0]   gpio_ahi_out,
    input  logic [HI_W-1:0]   gpio_ahi_oe,
    input  logic [2:0]        gpio_ctl_out,
    input  logic [2:0]        gpio_ctl_oe,
    output logic [DATA_W-1:0] pin_ad_out,
    output logic [DATA_W-1:0] pin_ad_oe,
    output logic [HI_W-1:0]   pin_ahi_out,
    output logic [HI_W-1:0]   pin_ahi_oe,
    output logic [2:0]        pin_ctl_out,
    output logic [2:0]        pin_ctl_oe
);

    generate
        for (genvar i = 0; i < DATA_W; i++) begin : g_ad
            assign pin_ad_out[i] = en ? bus_ad[i] : gpio_ad_out[i];
            assign pin_ad_oe[i]  = en ? bus_ad_oe : gpio_ad_oe[i];
        end
        for (genvar j = 0; j < HI_W; j++) begin : g_hi
            assign pin_ahi_out[j] = en ? bus_ahi[j] : gpio_ahi_out[j];
            assign pin_ahi_oe[j]  = en ? 1'b1       : gpio_ahi_oe[j];
        end
    endgenerate

    assign pin_ctl_out = en ? bus_ctl : gpio_ctl_out;
    assign pin_ctl_oe  = en ? 3'b111  : gpio_ctl_oe;

endmodule

// File: rtl/emb_bus_ctrl.sv
module emb_bus_ctrl
    import emb_pkg::*;
#(
    parameter int          DATA_W      = 8,
    parameter int          ADDR_W      = 16,
    parameter int unsigned RAM_TOP     = 32'h0000_10FF,
    parameter int unsigned SECTOR_STEP = 32'h0000_2000
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_we,
    input  logic                     cfg_addr,
    input  logic [REG_W-1:0]         cfg_wdata,
    output logic [REG_W-1:0]         cfg_rdata,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic                     req_we,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic [DATA_W-1:0]        rsp_rdata,
    input  logic                     next_ram_hint,
    input  logic [DATA_W-1:0]        gpio_ad_out,
    input  logic [DATA_W-1:0]        gpio_ad_oe,
    input  logic [ADDR_W-DATA_W-1:0] gpio_ahi_out,
    input  logic [ADDR_W-DATA_W-1:0] gpio_ahi_oe,
    input  logic [2:0]               gpio_ctl_out,
    input  logic [2:0]               gpio_ctl_oe,
    input  logic [DATA_W-1:0]        pin_ad_in,
    output logic [DATA_W-1:0]        pin_ad_out,
    output logic [DATA_W-1:0]        pin_ad_oe,
    output logic [ADDR_W-DATA_W-1:0] pin_ahi_out,
    output logic [ADDR_W-DATA_W-1:0] pin_ahi_oe,
    output logic [2:0]               pin_ctl_out,
    output logic [2:0]               pin_ctl_oe
);

    localparam int HI_W = ADDR_W - DATA_W;

    cfg_t              cfg_q;
    timing_t           req_tim;
    ctl_t              bus_ctl;
    logic [DATA_W-1:0] bus_ad;
    logic              bus_ad_oe;
    logic [HI_W-1:0]   bus_ahi;

    emb_cfg_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .cfg       (cfg_q)
    );

    emb_sector_sel #(
        .ADDR_W      (ADDR_W),
        .RAM_TOP     (RAM_TOP),
        .SECTOR_STEP (SECTOR_STEP)
    ) u_sect (
        .addr (req_addr),
        .cfg  (cfg_q),
        .tim  (req_tim)
    );

    emb_seq #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_seq (
        .clk           (clk),
        .rst           (rst),
        .en            (cfg_q.enable),
        .req_valid     (req_valid),
        .req_addr      (req_addr),
        .req_we        (req_we),
        .req_wdata     (req_wdata),
        .req_tim       (req_tim),
        .next_ram_hint (next_ram_hint),
        .ad_in         (pin_ad_in),
        .req_ready     (req_ready),
        .rsp_rdata     (rsp_rdata),
        .bus_ctl       (bus_ctl),
        .bus_ad        (bus_ad),
        .bus_ad_oe     (bus_ad_oe),
        .bus_ahi       (bus_ahi)
    );

    emb_pin_mux #(
        .DATA_W (DATA_W),
        .HI_W   (HI_W)
    ) u_mux (
        .en           (cfg_q.enable),
        .bus_ctl      (bus_ctl),
        .bus_ad       (bus_ad),
        .bus_ad_oe    (bus_ad_oe),
        .bus_ahi      (bus_ahi),
        .gpio_ad_out  (gpio_ad_out),
        .gpio_ad_oe   (gpio_ad_oe),
        .gpio_ahi_out (gpio_ahi_out),
        .gpio_ahi_oe  (gpio_ahi_oe),
        .gpio_ctl_out (gpio_ctl_out),
        .gpio_ctl_oe  (gpio_ctl_oe),
        .pin_ad_out   (pin_ad_out),
        .pin_ad_oe    (pin_ad_oe),
        .pin_ahi_out  (pin_ahi_out),
        .pin_ahi_oe   (pin_ahi_oe),
        .pin_ctl_out  (pin_ctl_out),
        .pin_ctl_oe   (pin_ctl_oe)
    );

endmodule

// File: rtl/emb_bus_ctrl_chk.sv
module emb_bus_ctrl_chk #(
    parameter int DATA_W = 8,
    parameter int HI_W   = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic              req_ready,
    input logic              next_ram_hint,
    input logic [DATA_W-1:0] gpio_ad_out,
    input logic [DATA_W-1:0] gpio_ad_oe,
    input logic [2:0]        gpio_ctl_out,
    input logic [2:0]        gpio_ctl_oe,
    input logic [DATA_W-1:0] pin_ad_out,
    input logic [DATA_W-1:0] pin_ad_oe,
    input logic [HI_W-1:0]   pin_ahi_oe,
    input logic [2:0]        pin_ctl_out,
    input logic [2:0]        pin_ctl_oe
);

    assert_ready_single_R11: assert property (@(posedge clk) disable iff (rst)
        req_ready |=> !req_ready);

    assert_strobes_exclusive_R12: assert property (@(posedge clk) disable iff (rst)
        en |-> (pin_ctl_out[1] || pin_ctl_out[0]));

    assert_ale_strobe_apart_R3: assert property (@(posedge clk) disable iff (rst)
        (en && pin_ctl_out[2]) |-> (pin_ctl_out[1] && pin_ctl_out[0]));

    assert_write_drives_R4: assert property (@(posedge clk) disable iff (rst)
        (en && !pin_ctl_out[1]) |-> (pin_ad_oe == '1));

    assert_read_releases_R5: assert property (@(posedge clk) disable iff (rst)
        (en && !pin_ctl_out[0]) |-> (pin_ad_oe == '0));

    assert_final_ale_R9: assert property (@(posedge clk) disable iff (rst)
        (en && req_ready) |-> (pin_ctl_out[2] == next_ram_hint));

    assert_port_passthru_R2: assert property (@(posedge clk) disable iff (rst)
        !en |-> (pin_ctl_out == gpio_ctl_out && pin_ctl_oe == gpio_ctl_oe &&
                 pin_ad_out == gpio_ad_out && pin_ad_oe == gpio_ad_oe));

    assert_pins_owned_R2: assert property (@(posedge clk) disable iff (rst)
        en |-> (pin_ctl_oe == 3'b111 && pin_ahi_oe == '1));

endmodule

bind emb_bus_ctrl emb_bus_ctrl_chk #(
    .DATA_W (DATA_W),
    .HI_W   (ADDR_W - DATA_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .en            (cfg_q.enable),
    .req_ready     (req_ready),
    .next_ram_hint (next_ram_hint),
    .gpio_ad_out   (gpio_ad_out),
    .gpio_ad_oe    (gpio_ad_oe),
    .gpio_ctl_out  (gpio_ctl_out),
    .gpio_ctl_oe   (gpio_ctl_oe),
    .pin_ad_out    (pin_ad_out),
    .pin_ad_oe     (pin_ad_oe),
    .pin_ahi_oe    (pin_ahi_oe),
    .pin_ctl_out   (pin_ctl_out),
    .pin_ctl_oe    (pin_ctl_oe)
);

// File: tb/emb_bus_ctrl_test.sv
module emb_bus_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic        cfg_addr = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_addr = '0;
    logic        req_we = 1'b0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  rsp_rdata;
    logic        next_ram_hint = 1'b0;
    logic [7:0]  gpio_ad_out = 8'h5A;
    logic [7:0]  gpio_ad_oe = 8'h0F;
    logic [7:0]  gpio_ahi_out = 8'hC3;
    logic [7:0]  gpio_ahi_oe = 8'hF0;
    logic [2:0]  gpio_ctl_out = 3'b101;
    logic [2:0]  gpio_ctl_oe = 3'b010;
    logic [7:0]  pin_ad_in = '0;
    logic [7:0]  pin_ad_out;
    logic [7:0]  pin_ad_oe;
    logic [7:0]  pin_ahi_out;
    logic [7:0]  pin_ahi_oe;
    logic [2:0]  pin_ctl_out;
    logic [2:0]  pin_ctl_oe;

    int n_cmp = 0;
    int n_bad = 0;

    // shadow of the configuration, kept from the requirements
    logic       sh_en = 1'b0;
    logic       sh_leg = 1'b0;
    logic [2:0] sh_lim = '0;
    logic [1:0] sh_up = '0;
    logic [1:0] sh_lo = '0;

    always #5 clk = ~clk;

    emb_bus_ctrl uut (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_we(req_we),
        .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .next_ram_hint(next_ram_hint),
        .gpio_ad_out(gpio_ad_out), .gpio_ad_oe(gpio_ad_oe), .gpio_ahi_out(gpio_ahi_out),
        .gpio_ahi_oe(gpio_ahi_oe), .gpio_ctl_out(gpio_ctl_out), .gpio_ctl_oe(gpio_ctl_oe),
        .pin_ad_in(pin_ad_in), .pin_ad_out(pin_ad_out), .pin_ad_oe(pin_ad_oe),
        .pin_ahi_out(pin_ahi_out), .pin_ahi_oe(pin_ahi_oe),
        .pin_ctl_out(pin_ctl_out), .pin_ctl_oe(pin_ctl_oe)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_passthru(input string tag);
        chk(tag, {pin_ad_out, pin_ad_oe, pin_ahi_out, pin_ahi_oe, pin_ctl_out, pin_ctl_oe, req_ready},
                 {gpio_ad_out, gpio_ad_oe, gpio_ahi_out, gpio_ahi_oe, gpio_ctl_out, gpio_ctl_oe, 1'b0});
    endtask

    task automatic wr_cfg(input logic sel, input logic [7:0] d, input logic [7:0] exp_rd, input string tag);
        cfg_we = 1'b1; cfg_addr = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel == 1'b0) begin
            sh_en = d[0]; sh_leg = d[1];
        end else begin
            sh_lim = d[6:4]; sh_up = d[3:2]; sh_lo = d[1:0];
        end
        chk(tag, 64'(cfg_rdata), 64'(exp_rd));
    endtask

    // R6 R7 R8 model: number of extra strobe cycles and hold cycle
    task automatic model_tim(input logic [15:0] a, output int w, output int h);
        int bound;
        logic [1:0] f;
        if (sh_leg) begin
            w = int'(sh_up[0]); h = 0;
        end else begin
            bound = 'h1100 + int'(sh_lim) * 'h2000;
            f = (sh_lim != 0 && int'(a) < bound) ? sh_lo : sh_up;
            w = (f == 2'd0) ? 0 : (f == 2'd1) ? 1 : 2;
            h = (f == 2'd3) ? 1 : 0;
        end
    endtask

    function automatic logic [63:0] pin_vec();
        return 64'({pin_ctl_out, pin_ad_oe, (pin_ad_oe != 0) ? pin_ad_out : 8'h00, pin_ahi_out, req_ready});
    endfunction

    function automatic logic [63:0] exp_vec(input logic [2:0] ctl, input logic [7:0] oe,
                                            input logic [7:0] ad, input logic [7:0] ahi, input logic rdy);
        return 64'({ctl, oe, (oe != 0) ? ad : 8'h00, ahi, rdy});
    endfunction

    task automatic access(input logic [15:0] a, input logic we, input logic [7:0] wd,
                          input logic [7:0] rv, input logic hint, input string tag);
        int w, h;
        model_tim(a, w, h);
        pin_ad_in = rv; next_ram_hint = hint;
        req_addr = a; req_we = we; req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        // R3 address cycle
        chk({tag, " R3 addr"}, pin_vec(), exp_vec(3'b111, 8'hFF, a[7:0], a[15:8], 1'b0));
        for (int i = 0; i <= w; i++) begin
            @(negedge clk);
            if (we) // R4
                chk({tag, " R4 R6 wstrobe"}, pin_vec(), exp_vec(3'b001, 8'hFF, wd, a[15:8], 1'b0));
            else    // R5
                chk({tag, " R5 R6 rstrobe"}, pin_vec(), exp_vec(3'b010, 8'h00, 8'h00, a[15:8], 1'b0));
        end
        if (h != 0) begin
            @(negedge clk);
            pin_ad_in = ~rv;
            chk({tag, " R6 hold"}, pin_vec(), exp_vec(3'b011, 8'h00, 8'h00, a[15:8], 1'b0));
        end
        @(negedge clk);
        pin_ad_in = ~rv;
        chk({tag, " R9 R11 final"}, pin_vec(), exp_vec({hint, 2'b11}, 8'h00, 8'h00, a[15:8], 1'b1));
        if (!we) chk({tag, " R5 rdata"}, 64'(rsp_rdata), 64'(rv));
        req_valid = 1'b0;
        @(negedge clk);
        chk({tag, " R11 idle"}, 64'(req_ready), 64'(0));
    endtask

    initial begin
        #2_000_000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        cfg_addr = 1'b0; #1;
        chk("R1 ctrl reset", 64'(cfg_rdata), 64'(0));
        cfg_addr = 1'b1; #1;
        chk("R1 sect reset", 64'(cfg_rdata), 64'(0));
        chk_passthru("R1 R2 pins after reset");

        // R2 disabled: request ignored, pins follow port logic
        req_addr = 16'h3456; req_we = 1'b1; req_valid = 1'b1;
        repeat (4) begin
            @(negedge clk);
            chk_passthru("R2 disabled no access");
        end
        req_valid = 1'b0;

        // R10 reserved bits
        wr_cfg(1'b0, 8'hFC, 8'h00, "R10 ctrl upper bits read 0");
        wr_cfg(1'b1, 8'hFF, 8'h7F, "R10 sect bit7 reads 0");
        wr_cfg(1'b0, 8'h01, 8'h01, "R2 enable");
        chk("R2 owned oe", 64'({pin_ctl_oe, pin_ahi_oe}), 64'({3'b111, 8'hFF}));

        // R7 limit 0: upper field only
        wr_cfg(1'b1, 8'h03, 8'h03, "R7 cfg lim0");
        access(16'h2000, 1'b1, 8'hA5, 8'h00, 1'b0, "R7 lim0 write");
        access(16'h1234, 1'b0, 8'h00, 8'h3C, 1'b1, "R7 lim0 read");
        // R6 each upper encoding
        wr_cfg(1'b1, 8'h04, 8'h04, "R6 cfg up01");
        access(16'h8001, 1'b1, 8'h11, 8'h00, 1'b1, "R6 up01 write");
        access(16'h8002, 1'b0, 8'h00, 8'h96, 1'b0, "R6 up01 read");
        wr_cfg(1'b1, 8'h08, 8'h08, "R6 cfg up10");
        access(16'h9003, 1'b0, 8'h00, 8'h69, 1'b1, "R6 up10 read");
        wr_cfg(1'b1, 8'h0C, 8'h0C, "R6 cfg up11");
        access(16'hA004, 1'b1, 8'hE7, 8'h00, 1'b0, "R6 up11 write");
        access(16'hA005, 1'b0, 8'h00, 8'h81, 1'b1, "R6 up11 read");

        // R7 boundary 2 -> 0x5100
        wr_cfg(1'b1, 8'h23, 8'h23, "R7 cfg lim2");
        access(16'h50FF, 1'b1, 8'h42, 8'h00, 1'b0, "R7 lim2 below");
        access(16'h5100, 1'b0, 8'h00, 8'h24, 1'b0, "R7 lim2 at edge");
        // R7 boundary 7 -> 0xF100
        wr_cfg(1'b1, 8'h76, 8'h76, "R7 cfg lim7");
        access(16'hF0FF, 1'b0, 8'h00, 8'hC9, 1'b1, "R7 lim7 below");
        access(16'hFFFF, 1'b1, 8'h3E, 8'h00, 1'b1, "R7 lim7 above");

        // R8 legacy mode
        wr_cfg(1'b0, 8'h03, 8'h03, "R8 legacy on");
        wr_cfg(1'b1, 8'h27, 8'h27, "R8 cfg up01 lo11");
        access(16'h2000, 1'b0, 8'h00, 8'h5D, 1'b0, "R8 legacy bit set");
        wr_cfg(1'b1, 8'h2B, 8'h2B, "R8 cfg up10 lo11");
        access(16'h2000, 1'b1, 8'hD5, 8'h00, 1'b1, "R8 legacy bit clear");

        // R2 disable again with new port values
        wr_cfg(1'b0, 8'h00, 8'h00, "R2 disable");
        gpio_ad_out = 8'h81; gpio_ad_oe = 8'hFF; gpio_ahi_out = 8'h18;
        gpio_ahi_oe = 8'h00; gpio_ctl_out = 3'b010; gpio_ctl_oe = 3'b101;
        #1;
        chk_passthru("R2 R12 disabled passthru");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule